// File: doc/BRIEF.md
# Fetch Stage Control Sequencer

This block decides, once per clock, what the front-end fetch stage of a processor does: fetch a new group of instructions, wait, or redirect. It takes squash requests from the commit and decode stages, a flag that says the reorder buffer is still draining after a squash, one stall flag per downstream stage, and the outcome of the current fetch (cache miss, translation fault). It also takes a notice that an outstanding cache miss has completed. It produces the stage state, a fetch pulse, a cache access request, a redirect PC pair with a valid strobe, a cancel strobe for an outstanding miss, and three saturating event counters.

Requests are resolved in a fixed order. A commit squash comes first. Then the reorder-buffer drain, then a decode squash, which is taken only when the stage is not already squashing. Stalls come last. A stall forces the blocked state from any state. Leaving the blocked state costs one cycle in which no fetch happens. A fetch that hits a translation fault parks the stage in the blocked state until a squash redirects it. A miss completion counts only while the stage still waits on that miss, so a completion that arrives after a squash is dropped. The cache, the branch predictor and the instruction datapath are outside the block. Each is reduced to a simple request or response pin.

Top module: `fetch_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the state at Idle and clears all counters. While reset is high, the fetch, access, redirect and cancel outputs stay low. State codes on `state_o` are Idle=0, Running=1, Blocked=2, Squashing=3, MissWait=4, MissDone=5.
- R2: A commit squash raises `redir_valid_o` in the same cycle, with `redir_pc_o` equal to the commit PC and `redir_npc_o` equal to that PC plus `INST_BYTES`. No fetch happens in that cycle, and the next state is Squashing.
- R3: `cancel_o` is high exactly in a cycle where a squash (commit, or an accepted decode squash) is taken while the state is MissWait.
- R4: When the reorder buffer still drains and there is no commit squash, the next state is Squashing. The squash counter increments and no fetch happens.
- R5: A decode squash is ignored (no redirect) while the state is Squashing. In any other state it redirects to the decode PC and enters Squashing.
- R6: If any stall flag is high and no squash is taken, the next state is Blocked. The blocked counter increments and no fetch happens, whatever the state was.
- R7: In Blocked with no stall, squash or pending fault, the next state is Running. No fetch happens in that cycle, and the blocked counter still increments.
- R8: In Idle, Running or Squashing with nothing pending, `fetch_o` and `access_o` are high in the same cycle. The next state is Running unless the fetch reports a miss or a fault.
- R9: A fetch reporting a miss moves the state to MissWait. A completion moves MissWait to MissDone, and a completion seen in any other state has no effect.
- R10: In MissDone with nothing pending, a fetch pulse is issued without a cache access. The state becomes Running, and the miss and fault inputs are ignored.
- R11: A fetch reporting a translation fault moves the state to Blocked. It stays there, with no fetch, until a commit or decode squash redirects it.
- R12: Each counter increments by one per event (fetch pulse, squash cycle, blocked cycle) and holds at its all-ones value.
- R13: When a commit squash and a decode squash arrive together, the redirect uses the commit PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmt_squash_i | input | 1 | Squash request from commit |
| cmt_pc_i | input | PC_W | Restart PC from commit |
| rob_busy_i | input | 1 | Reorder buffer still draining a squash |
| dec_squash_i | input | 1 | Squash request from decode |
| dec_pc_i | input | PC_W | Restart PC from decode |
| stall_i | input | NUM_STALL | Stall flags: decode, rename, execute, commit |
| miss_i | input | 1 | The access issued this cycle missed in the cache |
| fault_i | input | 1 | The access issued this cycle faulted in translation |
| miss_done_i | input | 1 | Outstanding miss has completed |
| state_o | output | 3 | Current state code |
| fetch_o | output | 1 | Fetch pulse for this cycle |
| access_o | output | 1 | Cache access request for this cycle |
| redir_valid_o | output | 1 | Redirect strobe |
| redir_pc_o | output | PC_W | Redirect PC |
| redir_npc_o | output | PC_W | Redirect PC plus one instruction |
| cancel_o | output | 1 | Cancel the outstanding cache miss |
| cnt_fetch_o | output | CNT_W | Fetch pulse counter |
| cnt_squash_o | output | CNT_W | Squash cycle counter |
| cnt_block_o | output | CNT_W | Blocked cycle counter |

## Verification
The fetch, access, redirect and cancel outputs depend only on the present inputs and state, so they are due in the same cycle as the stimulus. The bench drives inputs just after a rising edge and samples these outputs two nanoseconds later. The state and the counters pass through one register each, so they change at the next rising edge. The bench reads them just after that edge, before it drives the next stimulus. Each scenario resets the block first, so the expected counter values follow from that scenario's cycles alone.

// File: rtl/fetch_ctrl_pkg.sv
package fetch_ctrl_pkg;

   typedef enum logic [2:0] {
      FS_IDLE   = 3'd0,
      FS_RUN    = 3'd1,
      FS_BLOCK  = 3'd2,
      FS_SQUASH = 3'd3,
      FS_MWAIT  = 3'd4,
      FS_MDONE  = 3'd5
   } fstate_t;

   // event counter slots
   localparam int EV_FETCH  = 0;
   localparam int EV_SQUASH = 1;
   localparam int EV_BLOCK  = 2;
   localparam int NUM_EV    = 3;

endpackage

// File: rtl/fc_decide.sv
module fc_decide
   import fetch_ctrl_pkg::*;
(
   input  logic              rst,
   input  fstate_t           state_i,
   input  logic              hold_i,
   input  logic              cmt_squash_i,
   input  logic              rob_busy_i,
   input  logic              dec_squash_i,
   input  logic              stall_any_i,
   input  logic              miss_i,
   input  logic              fault_i,
   input  logic              miss_done_i,
   output fstate_t           next_o,
   output logic              take_cmt_o,
   output logic              take_dec_o,
   output logic              fetch_o,
   output logic              access_o,
   output logic              set_hold_o,
   output logic              clr_hold_o,
   output logic [NUM_EV-1:0] ev_o
);

   always_comb begin
      next_o     = state_i;
      take_cmt_o = 1'b0;
      take_dec_o = 1'b0;
      fetch_o    = 1'b0;
      access_o   = 1'b0;
      set_hold_o = 1'b0;
      clr_hold_o = 1'b0;
      ev_o       = '0;
      if (rst) begin
         next_o = FS_IDLE;
      end else if (cmt_squash_i) begin
         take_cmt_o        = 1'b1;
         clr_hold_o        = 1'b1;
         next_o            = FS_SQUASH;
         ev_o[EV_SQUASH]   = 1'b1;
      end else if (rob_busy_i) begin
         next_o            = FS_SQUASH;
         ev_o[EV_SQUASH]   = 1'b1;
      end else if (dec_squash_i && state_i != FS_SQUASH) begin
         take_dec_o        = 1'b1;
         clr_hold_o        = 1'b1;
         next_o            = FS_SQUASH;
         ev_o[EV_SQUASH]   = 1'b1;
      end else if (stall_any_i || hold_i) begin
         next_o            = FS_BLOCK;
         ev_o[EV_BLOCK]    = 1'b1;
      end else if (state_i == FS_BLOCK) begin
         next_o            = FS_RUN;
         ev_o[EV_BLOCK]    = 1'b1;
      end else if (state_i == FS_MWAIT) begin
         if (miss_done_i) next_o = FS_MDONE;
      end else begin
         fetch_o           = 1'b1;
         ev_o[EV_FETCH]    = 1'b1;
         if (state_i == FS_MDONE) begin
            next_o = FS_RUN;
         end else begin
            access_o = 1'b1;
            if (fault_i) begin
               next_o     = FS_BLOCK;
               set_hold_o = 1'b1;
            end else if (miss_i) begin
               next_o = FS_MWAIT;
            end else begin
               next_o = FS_RUN;
            end
         end
      end
   end

endmodule

// File: rtl/fc_redirect.sv
module fc_redirect #(
   parameter int PC_W       = 32,
   parameter int INST_BYTES = 4
) (
   input  logic            take_cmt_i,
   input  logic            take_dec_i,
   input  logic            in_mwait_i,
   input  logic [PC_W-1:0] cmt_pc_i,
   input  logic [PC_W-1:0] dec_pc_i,
   output logic            valid_o,
   output logic [PC_W-1:0] pc_o,
   output logic [PC_W-1:0] npc_o,
   output logic            cancel_o
);

   localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

   always_comb begin
      valid_o  = take_cmt_i | take_dec_i;
      pc_o     = take_cmt_i ? cmt_pc_i : dec_pc_i;
      npc_o    = pc_o + STEP;
      cancel_o = valid_o & in_mwait_i;
   end

endmodule

// File: rtl/fc_sat_ctr.sv
module fc_sat_ctr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (rst)                       cnt_o <= '0;
      else if (inc_i && cnt_o != TOP) cnt_o <= cnt_o + W'(1);
   end

endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
   import fetch_ctrl_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int CNT_W      = 32,
   parameter int NUM_STALL  = 4,
   parameter int INST_BYTES = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cmt_squash_i,
   input  logic [PC_W-1:0]      cmt_pc_i,
   input  logic                 rob_busy_i,
   input  logic                 dec_squash_i,
   input  logic [PC_W-1:0]      dec_pc_i,
   input  logic [NUM_STALL-1:0] stall_i,
   input  logic                 miss_i,
   input  logic                 fault_i,
   input  logic                 miss_done_i,
   output logic [2:0]           state_o,
   output logic                 fetch_o,
   output logic                 access_o,
   output logic                 redir_valid_o,
   output logic [PC_W-1:0]      redir_pc_o,
   output logic [PC_W-1:0]      redir_npc_o,
   output logic                 cancel_o,
   output logic [CNT_W-1:0]     cnt_fetch_o,
   output logic [CNT_W-1:0]     cnt_squash_o,
   output logic [CNT_W-1:0]     cnt_block_o
);

   if (PC_W < 4) begin : g_bad_pc
      $error("fetch_ctrl: PC_W must be at least 4");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("fetch_ctrl: CNT_W must be at least 2");
   end
   if (NUM_STALL < 1) begin : g_bad_stall
      $error("fetch_ctrl: NUM_STALL must be at least 1");
   end
   if (INST_BYTES < 1 || (INST_BYTES & (INST_BYTES - 1)) != 0) begin : g_bad_inst
      $error("fetch_ctrl: INST_BYTES must be a power of two");
   end

   fstate_t             state_q, state_d;
   logic                hold_q;
   logic                take_cmt, take_dec, set_hold, clr_hold;
   logic [NUM_EV-1:0]   ev;
   logic [CNT_W-1:0]    cnt [NUM_EV];

   fc_decide u_decide (
      .rst          (rst),
      .state_i      (state_q),
      .hold_i       (hold_q),
      .cmt_squash_i (cmt_squash_i),
      .rob_busy_i   (rob_busy_i),
      .dec_squash_i (dec_squash_i),
      .stall_any_i  (|stall_i),
      .miss_i       (miss_i),
      .fault_i      (fault_i),
      .miss_done_i  (miss_done_i),
      .next_o       (state_d),
      .take_cmt_o   (take_cmt),
      .take_dec_o   (take_dec),
      .fetch_o      (fetch_o),
      .access_o     (access_o),
      .set_hold_o   (set_hold),
      .clr_hold_o   (clr_hold),
      .ev_o         (ev)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= FS_IDLE;
         hold_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (clr_hold)      hold_q <= 1'b0;
         else if (set_hold) hold_q <= 1'b1;
      end
   end

   fc_redirect #(.PC_W(PC_W), .INST_BYTES(INST_BYTES)) u_redirect (
      .take_cmt_i (take_cmt),
      .take_dec_i (take_dec),
      .in_mwait_i (state_q == FS_MWAIT),
      .cmt_pc_i   (cmt_pc_i),
      .dec_pc_i   (dec_pc_i),
      .valid_o    (redir_valid_o),
      .pc_o       (redir_pc_o),
      .npc_o      (redir_npc_o),
      .cancel_o   (cancel_o)
   );

   for (genvar e = 0; e < NUM_EV; e++) begin : g_ctr
      fc_sat_ctr #(.W(CNT_W)) u_ctr (
         .clk   (clk),
         .rst   (rst),
         .inc_i (ev[e]),
         .cnt_o (cnt[e])
      );
   end

   assign state_o      = state_q;
   assign cnt_fetch_o  = cnt[EV_FETCH];
   assign cnt_squash_o = cnt[EV_SQUASH];
   assign cnt_block_o  = cnt[EV_BLOCK];

endmodule

// File: rtl/fetch_ctrl_chk.sv
module fetch_ctrl_chk
   import fetch_ctrl_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int CNT_W      = 32,
   parameter int NUM_STALL  = 4
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 cmt_squash_i,
   input logic [PC_W-1:0]      cmt_pc_i,
   input logic                 rob_busy_i,
   input logic                 dec_squash_i,
   input logic [NUM_STALL-1:0] stall_i,
   input logic                 miss_done_i,
   input logic [2:0]           state_o,
   input logic                 fetch_o,
   input logic                 access_o,
   input logic                 redir_valid_o,
   input logic [PC_W-1:0]      redir_pc_o,
   input logic                 cancel_o,
   input logic [CNT_W-1:0]     cnt_fetch_o
);

   localparam logic [CNT_W-1:0] CMAX = '1;

   logic quiet_sq;
   assign quiet_sq = !cmt_squash_i && !rob_busy_i &&
                     !(dec_squash_i && state_o != FS_SQUASH);

   // R1: quiet outputs while reset is held
   always_comb begin
      if (rst) p_reset_quiet_r1: assert (!fetch_o && !access_o && !redir_valid_o && !cancel_o);
   end

   p_cmt_redirect_r2: assert property (@(posedge clk) disable iff (rst)
      cmt_squash_i |-> redir_valid_o && redir_pc_o == cmt_pc_i && !fetch_o);

   p_cmt_state_r2: assert property (@(posedge clk) disable iff (rst)
      cmt_squash_i |=> state_o == FS_SQUASH);

   p_cancel_r3: assert property (@(posedge clk) disable iff (rst)
      cancel_o |-> state_o == FS_MWAIT && redir_valid_o);

   p_rob_r4: assert property (@(posedge clk) disable iff (rst)
      rob_busy_i && !cmt_squash_i |=> state_o == FS_SQUASH);

   p_dec_ignored_r5: assert property (@(posedge clk) disable iff (rst)
      !cmt_squash_i && state_o == FS_SQUASH |-> !redir_valid_o);

   p_stall_r6: assert property (@(posedge clk) disable iff (rst)
      (|stall_i) && quiet_sq |=> state_o == FS_BLOCK);

   p_block_nofetch_r7: assert property (@(posedge clk) disable iff (rst)
      state_o == FS_BLOCK |-> !fetch_o);

   p_miss_done_r9: assert property (@(posedge clk) disable iff (rst)
      state_o == FS_MWAIT && miss_done_i && quiet_sq && !(|stall_i) |=> state_o == FS_MDONE);

   p_noaccess_r10: assert property (@(posedge clk) disable iff (rst)
      state_o == FS_MDONE |-> !access_o);

   p_fetch_count_r12: assert property (@(posedge clk) disable iff (rst)
      fetch_o |=> cnt_fetch_o == (($past(cnt_fetch_o) == CMAX) ? CMAX
                                   : $past(cnt_fetch_o) + CNT_W'(1)));

   p_fetch_hold_r12: assert property (@(posedge clk) disable iff (rst)
      !fetch_o |=> $stable(cnt_fetch_o));

endmodule

bind fetch_ctrl fetch_ctrl_chk #(
   .PC_W(PC_W), .CNT_W(CNT_W), .NUM_STALL(NUM_STALL)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .cmt_squash_i  (cmt_squash_i),
   .cmt_pc_i      (cmt_pc_i),
   .rob_busy_i    (rob_busy_i),
   .dec_squash_i  (dec_squash_i),
   .stall_i       (stall_i),
   .miss_done_i   (miss_done_i),
   .state_o       (state_o),
   .fetch_o       (fetch_o),
   .access_o      (access_o),
   .redir_valid_o (redir_valid_o),
   .redir_pc_o    (redir_pc_o),
   .cancel_o      (cancel_o),
   .cnt_fetch_o   (cnt_fetch_o)
);

// File: tb/fetch_ctrl_bench.sv
module fetch_ctrl_bench;

   localparam int PC_W = 32;
   localparam int CW   = 6;
   localparam int NS   = 4;

   localparam logic [2:0] S_IDLE = 3'd0, S_RUN = 3'd1, S_BLOCK = 3'd2,
                          S_SQ = 3'd3, S_MWAIT = 3'd4, S_MDONE = 3'd5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cmt_squash, rob_busy, dec_squash, miss, fault, done;
   logic [PC_W-1:0] cmt_pc, dec_pc;
   logic [NS-1:0]   stall;
   logic [2:0]      state;
   logic fetch, access, rvalid, cancel;
   logic [PC_W-1:0] rpc, rnpc;
   logic [CW-1:0]   c_fetch, c_sq, c_blk;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   fetch_ctrl #(.PC_W(PC_W), .CNT_W(CW), .NUM_STALL(NS), .INST_BYTES(4)) u_fetch_ctrl (
      .clk(clk), .rst(rst),
      .cmt_squash_i(cmt_squash), .cmt_pc_i(cmt_pc), .rob_busy_i(rob_busy),
      .dec_squash_i(dec_squash), .dec_pc_i(dec_pc), .stall_i(stall),
      .miss_i(miss), .fault_i(fault), .miss_done_i(done),
      .state_o(state), .fetch_o(fetch), .access_o(access),
      .redir_valid_o(rvalid), .redir_pc_o(rpc), .redir_npc_o(rnpc),
      .cancel_o(cancel), .cnt_fetch_o(c_fetch), .cnt_squash_o(c_sq), .cnt_block_o(c_blk)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic quiet();
      cmt_squash = 0; rob_busy = 0; dec_squash = 0; miss = 0; fault = 0; done = 0;
      cmt_pc = '0; dec_pc = '0; stall = '0;
   endtask

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      quiet(); rst = 1; cyc(); cyc(); rst = 0;
   endtask

   task automatic t_reset();
      quiet(); rst = 1; cyc(); #2;
      chk("R1 fetch low in reset", fetch, 0);
      chk("R1 access low in reset", access, 0);
      rst = 0; #1;
      chk("R1 state idle", state, S_IDLE);
      chk("R1 fetch count zero", c_fetch, 0);
      chk("R1 squash count zero", c_sq, 0);
      chk("R1 block count zero", c_blk, 0);
   endtask

   task automatic t_fetch();
      do_reset(); #2;
      chk("R8 fetch from idle", fetch, 1);
      chk("R8 access from idle", access, 1);
      cyc();
      chk("R8 state running", state, S_RUN);
      #2 chk("R8 fetch while running", fetch, 1);
      cyc();
      chk("R12 fetch count 2", c_fetch, 2);
   endtask

   task automatic t_cmt();
      do_reset(); cyc();
      cmt_squash = 1; cmt_pc = 32'h1000; dec_squash = 1; dec_pc = 32'h2000; stall = 4'b0001;
      #2;
      chk("R2 redirect valid", rvalid, 1);
      chk("R13 commit pc wins", rpc, 32'h1000);
      chk("R2 next pc", rnpc, 32'h1004);
      chk("R2 no fetch on squash", fetch, 0);
      chk("R3 no cancel outside miss", cancel, 0);
      cyc(); quiet();
      chk("R2 state squashing", state, S_SQ);
      chk("R2 squash count", c_sq, 1);
      chk("R6 stall lost to squash", c_blk, 0);
      #2 chk("R8 fetch leaving squash", fetch, 1);
      cyc();
      chk("R8 running after squash", state, S_RUN);
   endtask

   task automatic t_rob();
      do_reset();
      cmt_squash = 1; cmt_pc = 32'h40; cyc(); quiet();
      rob_busy = 1;
      for (int i = 0; i < 2; i++) begin
         #2 chk("R4 no fetch while draining", fetch, 0);
         cyc();
         chk("R4 still squashing", state, S_SQ);
      end
      chk("R4 squash count", c_sq, 3);
      rob_busy = 0; dec_squash = 1; dec_pc = 32'h80;
      #2;
      chk("R5 decode squash ignored", rvalid, 0);
      chk("R5 fetch falls through", fetch, 1);
      cyc();
      chk("R5 running", state, S_RUN);
      #2;
      chk("R5 decode redirect", rvalid, 1);
      chk("R5 decode pc", rpc, 32'h80);
      chk("R5 decode next pc", rnpc, 32'h84);
      chk("R3 no cancel in running", cancel, 0);
      cyc(); quiet();
      chk("R5 squashing", state, S_SQ);
      chk("R5 squash count", c_sq, 4);
   endtask

   task automatic t_stall();
      do_reset(); cyc();
      for (int i = 0; i < NS; i++) begin
         stall = NS'(1) << i;
         #2 chk("R6 no fetch on stall", fetch, 0);
         cyc();
         chk("R6 blocked", state, S_BLOCK);
      end
      quiet();
      #2 chk("R7 no fetch on unblock", fetch, 0);
      cyc();
      chk("R7 running", state, S_RUN);
      chk("R7 block count", c_blk, 5);
      #2 chk("R8 fetch after unblock", fetch, 1);
   endtask

   task automatic t_miss();
      do_reset();
      miss = 1; #2 chk("R9 access issued", access, 1);
      cyc(); quiet();
      chk("R9 miss wait", state, S_MWAIT);
      #2 chk("R9 no fetch in miss wait", fetch, 0);
      cyc();
      chk("R9 still waiting", state, S_MWAIT);
      done = 1; cyc(); done = 0;
      chk("R9 miss done", state, S_MDONE);
      miss = 1; fault = 1;
      #2;
      chk("R10 fetch pulse", fetch, 1);
      chk("R10 no access", access, 0);
      cyc(); quiet();
      chk("R10 running", state, S_RUN);
      chk("R12 fetch count", c_fetch, 2);
   endtask

   task automatic t_late();
      do_reset();
      miss = 1; cyc(); quiet();
      cmt_squash = 1; cmt_pc = 32'h300;
      #2 chk("R3 cancel on squash in miss wait", cancel, 1);
      cyc(); quiet();
      chk("R3 squashing", state, S_SQ);
      done = 1;
      #2 chk("R9 fetch with late completion", access, 1);
      cyc(); quiet();
      chk("R9 late completion ignored", state, S_RUN);
   endtask

   task automatic t_fault();
      do_reset();
      fault = 1; #2 chk("R11 fetch issued", fetch, 1);
      cyc(); quiet();
      chk("R11 blocked on fault", state, S_BLOCK);
      for (int i = 0; i < 3; i++) begin
         #2 chk("R11 no fetch while faulted", fetch, 0);
         cyc();
         chk("R11 stays blocked", state, S_BLOCK);
      end
      chk("R11 block count", c_blk, 3);
      dec_squash = 1; dec_pc = 32'h500;
      #2 chk("R11 squash redirects", rvalid, 1);
      cyc(); quiet();
      chk("R11 squashing", state, S_SQ);
      cyc();
      chk("R11 running again", state, S_RUN);
   endtask

   task automatic t_sat();
      do_reset();
      stall = 4'b1000;
      repeat (70) cyc();
      chk("R12 block count saturates", c_blk, 63);
      chk("R6 blocked", state, S_BLOCK);
      quiet();
   endtask

   initial begin
      quiet();
      t_reset();
      t_fetch();
      t_cmt();
      t_rob();
      t_stall();
      t_miss();
      t_late();
      t_fault();
      t_sat();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule